// File: doc/BRIEF.md
# Stacked Chip-Select Region Decoder

This block turns an address in a memory-mapped flash window into a one-hot chip select and a byte offset inside the selected device. Four device regions sit back to back, starting at address zero. Each region's length comes from its own size input, given in kilobytes. No region has a fixed base address. The base of a region is the sum of the byte sizes of all regions below it. A region whose size is zero holds no address range and never gets selected.

The block sits between the memory-mapped read path and the serial engine. Each cycle in which `req_valid` is high it decodes `req_addr` against the current size inputs. It presents the registered result one cycle later on `rsp_valid`, `rsp_cs`, `rsp_offset` and `rsp_err`. An address at or above the end of the highest mapped region is reported as an error and drives no chip select.

Top module: `csd_stack`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_cs`, `rsp_offset` and `rsp_err` are all zero.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` was high, and low otherwise. Back-to-back requests each produce their own result in consecutive cycles.
- R3: Region k occupies slot k of `region_kb`, which is bits [k*KB_W +: KB_W]. Its byte size is its field value multiplied by 1024. Region 0 starts at address 0, and region k starts where region k-1 ends.
- R4: For an address inside a mapped region k, `rsp_cs` is one-hot with bit k set.
- R5: For an address inside region k, `rsp_offset` equals the address minus the start of region k, so it is always less than the byte size of region k.
- R6: A region whose size field is zero is never selected, even when its start address equals the request address. The address goes to the next non-empty region above it.
- R7: An address at or beyond the sum of all four byte sizes sets `rsp_err`, with `rsp_cs` and `rsp_offset` zero. If all sizes are zero, every address gives this result.
- R8: In a cycle where `rsp_valid` is low, `rsp_cs`, `rsp_offset` and `rsp_err` are zero.
- R9: Whenever `rsp_valid` is high, exactly one of these holds: one bit of `rsp_cs` is set, or `rsp_err` is set.
- R10: Region bounds are computed wider than the address, so a map whose total size exceeds the address space does not wrap. Every address then falls into a region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_kb | input | NUM_CS*KB_W (88) | Size of each region in KB; region k in bits [k*KB_W +: KB_W] |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W (32) | Address to decode |
| rsp_valid | output | 1 | Registered result valid |
| rsp_cs | output | NUM_CS (4) | One-hot chip select |
| rsp_offset | output | ADDR_W (32) | Offset within the selected device |
| rsp_err | output | 1 | Address beyond the mapped range |

## Verification
Equal 4 KB regions are probed at each region's first and last byte and at the first byte past the map. This separates off-by-one faults in the start and end comparisons and in the subtraction. An uneven map (1, 8, 2 and 16 KB) shows that each base is a running sum and not a multiple of one size. A map with empty regions 0 and 2 uses addresses that land exactly on an empty region's start, so a decoder that skips the zero-size gate picks the wrong select. An all-empty map, a maximum-size map that overruns the 32-bit space, and back-to-back and idle cycles cover the error path, wide bounds and the one-cycle latency.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // A size field counts kilobytes: byte size is the field shifted by this much.
    localparam int KB_SHIFT   = 10;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_NUM_CS = 4;

    // Outcome of one decode.
    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_HIT  = 2'd1,
        OUT_MISS = 2'd2
    } outcome_e;

    // Width that holds the sum of all region sizes without wrapping.
    function automatic int sum_width(input int addr_w, input int num_cs);
        return addr_w + $clog2(num_cs + 1);
    endfunction

endpackage

// File: rtl/csd_bounds.sv
module csd_bounds
    import csd_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int NUM_CS = DEF_NUM_CS,
    localparam int KB_W   = ADDR_W - KB_SHIFT,
    localparam int SUM_W  = sum_width(ADDR_W, NUM_CS)
) (
    input  logic [NUM_CS*KB_W-1:0]  region_kb_i,
    output logic [NUM_CS*SUM_W-1:0] base_o,
    output logic [NUM_CS*SUM_W-1:0] limit_o,
    output logic [NUM_CS-1:0]       nonzero_o
);

    localparam int PAD_W = SUM_W - KB_W - KB_SHIFT;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CS; gi++) begin : g_region
            logic [KB_W-1:0]  kb;
            logic [SUM_W-1:0] bytes;
            logic [SUM_W-1:0] base;

            assign kb    = region_kb_i[gi*KB_W +: KB_W];
            assign bytes = {{PAD_W{1'b0}}, kb, {KB_SHIFT{1'b0}}};

            if (gi == 0) begin : g_first
                assign base = '0;
            end else begin : g_next
                assign base = limit_o[(gi-1)*SUM_W +: SUM_W];
            end

            assign base_o[gi*SUM_W +: SUM_W]  = base;
            assign limit_o[gi*SUM_W +: SUM_W] = base + bytes;
            assign nonzero_o[gi]              = |kb;
        end
    endgenerate

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int NUM_CS = DEF_NUM_CS,
    localparam int SUM_W  = sum_width(ADDR_W, NUM_CS)
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [NUM_CS*SUM_W-1:0] base_i,
    input  logic [NUM_CS*SUM_W-1:0] limit_i,
    input  logic [NUM_CS-1:0]       nonzero_i,
    output logic [NUM_CS-1:0]       hit_o,
    output logic                    beyond_o
);

    logic [SUM_W-1:0] addr_x;
    assign addr_x = {{(SUM_W-ADDR_W){1'b0}}, addr_i};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CS; gi++) begin : g_cmp
            logic at_or_above;
            logic below_end;
            assign at_or_above = addr_x >= base_i[gi*SUM_W +: SUM_W];
            assign below_end   = addr_x <  limit_i[gi*SUM_W +: SUM_W];
            // An empty region is gated off even when its base equals the address.
            assign hit_o[gi]   = nonzero_i[gi] & at_or_above & below_end;
        end
    endgenerate

    assign beyond_o = addr_x >= limit_i[(NUM_CS-1)*SUM_W +: SUM_W];

endmodule

// File: rtl/csd_select.sv
module csd_select
    import csd_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int NUM_CS = DEF_NUM_CS,
    localparam int SUM_W  = sum_width(ADDR_W, NUM_CS)
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [NUM_CS*SUM_W-1:0] base_i,
    input  logic [NUM_CS-1:0]       hit_i,
    input  logic                    beyond_i,
    output outcome_e                outcome_o,
    output logic [NUM_CS-1:0]       cs_o,
    output logic [ADDR_W-1:0]       offset_o
);

    logic [SUM_W-1:0] addr_x;
    logic [SUM_W-1:0] off_w;

    assign addr_x = {{(SUM_W-ADDR_W){1'b0}}, addr_i};

    always_comb begin
        off_w = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit_i[i]) begin
                off_w = off_w | (addr_x - base_i[i*SUM_W +: SUM_W]);
            end
        end
    end

    always_comb begin
        if (beyond_i) begin
            outcome_o = OUT_MISS;
            cs_o      = '0;
            offset_o  = '0;
        end else if (|hit_i) begin
            outcome_o = OUT_HIT;
            cs_o      = hit_i;
            offset_o  = off_w[ADDR_W-1:0];
        end else begin
            outcome_o = OUT_NONE;
            cs_o      = '0;
            offset_o  = '0;
        end
    end

endmodule

// File: rtl/csd_stack.sv
module csd_stack
    import csd_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int NUM_CS = DEF_NUM_CS,
    localparam int KB_W   = ADDR_W - KB_SHIFT,
    localparam int SUM_W  = sum_width(ADDR_W, NUM_CS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CS*KB_W-1:0] region_kb,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   rsp_valid,
    output logic [NUM_CS-1:0]      rsp_cs,
    output logic [ADDR_W-1:0]      rsp_offset,
    output logic                   rsp_err
);

    typedef struct packed {
        logic              valid;
        logic [NUM_CS-1:0] cs;
        logic [ADDR_W-1:0] offset;
        logic              err;
    } result_t;

    logic [NUM_CS*SUM_W-1:0] base_w;
    logic [NUM_CS*SUM_W-1:0] limit_w;
    logic [NUM_CS-1:0]       nonzero_w;
    logic [NUM_CS-1:0]       hit_w;
    logic                    beyond_w;
    outcome_e                outcome_w;
    logic [NUM_CS-1:0]       cs_w;
    logic [ADDR_W-1:0]       offset_w;
    result_t                 res_q;

    csd_bounds #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_bounds (
        .region_kb_i (region_kb),
        .base_o      (base_w),
        .limit_o     (limit_w),
        .nonzero_o   (nonzero_w)
    );

    csd_match #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_match (
        .addr_i    (req_addr),
        .base_i    (base_w),
        .limit_i   (limit_w),
        .nonzero_i (nonzero_w),
        .hit_o     (hit_w),
        .beyond_o  (beyond_w)
    );

    csd_select #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_select (
        .addr_i    (req_addr),
        .base_i    (base_w),
        .hit_i     (hit_w),
        .beyond_i  (beyond_w),
        .outcome_o (outcome_w),
        .cs_o      (cs_w),
        .offset_o  (offset_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (req_valid) begin
            res_q.valid  <= 1'b1;
            res_q.cs     <= cs_w;
            res_q.offset <= offset_w;
            res_q.err    <= (outcome_w == OUT_MISS);
        end else begin
            res_q <= '0;
        end
    end

    assign rsp_valid  = res_q.valid;
    assign rsp_cs     = res_q.cs;
    assign rsp_offset = res_q.offset;
    assign rsp_err    = res_q.err;

endmodule

// File: rtl/csd_stack_chk.sv
module csd_stack_chk
    import csd_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    parameter  int NUM_CS = DEF_NUM_CS,
    localparam int KB_W   = ADDR_W - KB_SHIFT,
    localparam int SUM_W  = sum_width(ADDR_W, NUM_CS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CS*KB_W-1:0] region_kb,
    input logic                   req_valid,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   rsp_valid,
    input logic [NUM_CS-1:0]      rsp_cs,
    input logic [ADDR_W-1:0]      rsp_offset,
    input logic                   rsp_err
);

    logic [NUM_CS*KB_W-1:0] kb_q;
    logic [SUM_W-1:0]       sel_bytes;
    logic [SUM_W-1:0]       off_x;

    always_ff @(posedge clk) begin
        if (rst) kb_q <= '0;
        else     kb_q <= region_kb;
    end

    always_comb begin
        sel_bytes = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rsp_cs[i]) begin
                sel_bytes = sel_bytes |
                    {{(SUM_W-ADDR_W){1'b0}}, kb_q[i*KB_W +: KB_W], {KB_SHIFT{1'b0}}};
            end
        end
    end

    assign off_x = {{(SUM_W-ADDR_W){1'b0}}, rsp_offset};

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    idle_follows_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_cs == '0 && rsp_offset == '0 && !rsp_err));

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_cs, rsp_err}) == 1));

    // R7
    miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_cs == '0 && rsp_offset == '0));

    // R5
    offset_inside_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> (off_x < sel_bytes));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CS; gi++) begin : g_zero
            // R6
            empty_never_chosen_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_cs[gi] |-> (kb_q[gi*KB_W +: KB_W] != '0));
        end
    endgenerate

endmodule

bind csd_stack csd_stack_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .region_kb  (region_kb),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_cs     (rsp_cs),
    .rsp_offset (rsp_offset),
    .rsp_err    (rsp_err)
);

// File: tb/csd_stack_test.sv
module csd_stack_test;

    localparam int ADDR_W = 32;
    localparam int NUM_CS = 4;
    localparam int KB_W   = ADDR_W - 10;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NUM_CS*KB_W-1:0] region_kb = '0;
    logic                   req_valid = 1'b0;
    logic [ADDR_W-1:0]      req_addr  = '0;
    logic                   rsp_valid;
    logic [NUM_CS-1:0]      rsp_cs;
    logic [ADDR_W-1:0]      rsp_offset;
    logic                   rsp_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    longint unsigned kb_model [NUM_CS];

    csd_stack #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) uut (
        .clk        (clk),
        .rst        (rst),
        .region_kb  (region_kb),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .rsp_valid  (rsp_valid),
        .rsp_cs     (rsp_cs),
        .rsp_offset (rsp_offset),
        .rsp_err    (rsp_err)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_sizes(input longint unsigned k0, input longint unsigned k1,
                             input longint unsigned k2, input longint unsigned k3);
        kb_model[0] = k0; kb_model[1] = k1; kb_model[2] = k2; kb_model[3] = k3;
        @(negedge clk);
        for (int i = 0; i < NUM_CS; i++)
            region_kb[i*KB_W +: KB_W] = kb_model[i][KB_W-1:0];
    endtask

    // Expected decode from the requirement text (R3..R7, R10).
    task automatic expect_dec(input longint unsigned a, output logic [NUM_CS-1:0] cs,
                              output longint unsigned off, output logic err);
        longint unsigned start = 0;
        cs = '0; off = 0;
        for (int i = 0; i < NUM_CS; i++) begin
            longint unsigned len = kb_model[i] * 1024;
            if (len != 0 && a >= start && a < start + len) begin
                cs[i] = 1'b1;
                off   = a - start;
            end
            start += len;
        end
        err = (a >= start);
    endtask

    task automatic check_result(input longint unsigned a, input string tag);
        logic [NUM_CS-1:0] ecs; longint unsigned eoff; logic eerr;
        expect_dec(a, ecs, eoff, eerr);
        check({"R2 valid ", tag}, rsp_valid, 1);
        check({"R4 cs ", tag}, rsp_cs, ecs);
        check({"R5 offset ", tag}, rsp_offset, eoff);
        check({"R7 err ", tag}, rsp_err, eerr);
    endtask

    task automatic probe(input longint unsigned a, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a[ADDR_W-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        check_result(a, tag);
    endtask

    task automatic t_reset;
        check("R1 valid", rsp_valid, 0);
        check("R1 cs", rsp_cs, 0);
        check("R1 offset", rsp_offset, 0);
        check("R1 err", rsp_err, 0);
    endtask

    task automatic t_uniform;
        set_sizes(4, 4, 4, 4);
        probe(0,          "R3 uniform first byte");
        probe(4095,       "R3 uniform end of region 0");
        probe(4096,       "R3 uniform start of region 1");
        probe(12288 + 5,  "R3 uniform inside region 3");
        probe(16383,      "R3 uniform last byte");
        probe(16384,      "R7 uniform first past end");
    endtask

    task automatic t_uneven;
        set_sizes(1, 8, 2, 16);
        probe(1023,   "R3 uneven end of region 0");
        probe(1024,   "R3 uneven start of region 1");
        probe(9215,   "R3 uneven end of region 1");
        probe(9216,   "R3 uneven start of region 2");
        probe(11264,  "R3 uneven start of region 3");
        probe(27647,  "R3 uneven last byte");
        probe(27648,  "R7 uneven past end");
        probe(32'hFFFF_FFFF, "R7 uneven top address");
    endtask

    task automatic t_zero;
        set_sizes(0, 4, 0, 4);
        probe(0,    "R6 empty region 0 start");
        probe(4096, "R6 empty region 2 start");
        probe(8191, "R6 last byte");
        probe(8192, "R7 past end with holes");
        set_sizes(0, 0, 0, 0);
        probe(0,    "R7 all empty");
    endtask

    task automatic t_wide;
        set_sizes(64'h3F_FFFF, 64'h3F_FFFF, 64'h3F_FFFF, 64'h3F_FFFF);
        probe(32'hFFFF_FBFF, "R10 end of region 0");
        probe(32'hFFFF_FFFF, "R10 top address in region 1");
    endtask

    task automatic t_pipeline;
        set_sizes(4, 4, 4, 4);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'd100;
        @(negedge clk);
        req_addr = 32'd8200;
        check_result(100, "R2 back-to-back first");
        @(negedge clk);
        req_valid = 1'b0;
        check_result(8200, "R2 back-to-back second");
        @(negedge clk);
        check("R8 idle valid", rsp_valid, 0);
        check("R8 idle cs", rsp_cs, 0);
        check("R8 idle offset", rsp_offset, 0);
        check("R8 idle err", rsp_err, 0);
        check("R9 idle hold", rsp_valid, 0);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_uneven();
        t_zero();
        t_wide();
        t_pipeline();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

endmodule